// File: doc/BRIEF.md
# Control Endpoint Phase Event Tracker

This block watches the transaction stream seen by one USB device control OUT endpoint and keeps a small set of sticky event flags for software. A protocol engine feeds it decoded, one-cycle event strobes: SETUP, OUT and IN tokens, a good data packet, CRC and overflow errors, babble, NAK sent and NYET sent. The block also receives the endpoint enable level, a drained indication from the receive path and a threshold-mode enable.

The tracker counts SETUP packets received one after another. It holds back "setup complete" until the host sends the next IN or OUT token. At that token it raises the setup-complete flag and pulses an endpoint auto-disable for one cycle. It also flags these events:
- an OUT token that arrives while the endpoint is disabled;
- an IN token that ends the data stage of a control write, once the receive path is drained;
- packet errors while threshold mode is on;
- line and handshake events.

Software clears any flag by writing 1 to its bit. A masked OR of the flags drives one interrupt line.

Top module: `ctl_ep_event_tracker`

## Requirements
- R1: While `rst` is high at a rising clock edge, all flags, the SETUP counter, the pending-setup state and the status-phase state are cleared. After reset `flags` = 0, `irq` = 0 and `ep_dis_pulse` = 0. An IN or OUT token given before any SETUP packet sets no setup-complete flag.
- R2: A SETUP packet is a `tok_setup` strobe followed later by a `data_ok` strobe, with no IN or OUT token between them. The setup-complete flag (bit 0) is set by the first `tok_in` or `tok_out` after one or more SETUP packets. It is not set before that token, and the flag appears on the clock edge after the token cycle.
- R3: `ep_dis_pulse` is high for exactly the one cycle in which bit 0 is newly set by a completing token, and is low otherwise.
- R4: The back-to-back flag (bit 1) is set on the fourth SETUP packet that arrives with no IN or OUT token between them, and on every later packet in that run. Three such packets leave bit 1 clear. Any IN or OUT token resets the count.
- R5: `tok_out` while `ep_en` is low sets bit 2. An OUT token while `ep_en` is high, or an IN token at any time, leaves bit 2 clear.
- R6: The status-phase flag (bit 3) is armed by an IN token that follows an OUT token accepted with `ep_en` high and no setup pending. It is set on the first edge at which `data_drained` is high, and no earlier. An IN token with no accepted OUT data since the last SETUP never sets it.
- R7: The packet-error flag (bit 4) is set by `crc_err` or `ovf_err` only when `thresh_en` is high.
- R8: `babble` sets bit 5, `nak_evt` sets bit 6 and `nyet_evt` sets bit 7, each without touching the other bits.
- R9: Writing 1 to a bit of `flag_clr` clears that flag on the next edge, and other flags are kept. If a set event and a clear of the same bit fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some bit is set in both `flags` and `irq_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_setup | input | 1 | SETUP token strobe |
| tok_out | input | 1 | OUT token strobe |
| tok_in | input | 1 | IN token strobe |
| data_ok | input | 1 | Good data packet received strobe |
| crc_err | input | 1 | OUT packet CRC error strobe |
| ovf_err | input | 1 | OUT packet overflow strobe |
| babble | input | 1 | Babble detected strobe |
| nak_evt | input | 1 | NAK sent or received strobe |
| nyet_evt | input | 1 | NYET sent strobe |
| ep_en | input | 1 | Endpoint enable level |
| data_drained | input | 1 | Data stage fully moved to memory |
| thresh_en | input | 1 | Threshold mode enable |
| flag_clr | input | 8 | Write-1-to-clear strobes, one per flag |
| irq_mask | input | 8 | Per-flag interrupt enable |
| flags | output | 8 | Sticky event flags |
| irq | output | 1 | Masked OR of flags |
| ep_dis_pulse | output | 1 | One-cycle endpoint auto-disable |

## Verification
Two functions can fall in the same cycle: a software clear of a flag and a new event that sets the same flag. The bench sets the NAK flag, then drives `nak_evt` and that bit of `flag_clr` in one cycle, and expects the bit to read 1 afterwards. Clears without a set event, and clears of another bit, are checked as well. A second case of this kind is the token that both completes the setup stage and resets the back-to-back count. Sweeps over the number of SETUP packets followed by an IN or an OUT token show that both effects come from one token.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    localparam int FLAG_W = 8;

    // flag positions inside the sticky vector
    localparam int F_SETUP_DONE = 0;
    localparam int F_B2B_SETUP  = 1;
    localparam int F_OUT_DIS    = 2;
    localparam int F_STATUS_RX  = 3;
    localparam int F_PKT_ERR    = 4;
    localparam int F_BABBLE     = 5;
    localparam int F_NAK        = 6;
    localparam int F_NYET       = 7;

    typedef logic [FLAG_W-1:0] flag_vec_t;

    typedef struct packed {
        logic tok_setup;
        logic tok_out;
        logic tok_in;
        logic data_ok;
        logic crc_err;
        logic ovf_err;
        logic babble;
        logic nak;
        logic nyet;
    } ep_evt_t;

    function automatic logic any_data_token(input ep_evt_t e);
        return e.tok_in | e.tok_out;
    endfunction

endpackage

// File: rtl/ctl_ep_phase_fsm.sv
module ctl_ep_phase_fsm
    import ctl_ep_pkg::*;
#(
    parameter int B2B_LIMIT = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  ep_evt_t   ev,
    input  logic      ep_en,
    input  logic      data_drained,
    input  logic      thresh_en,
    output flag_vec_t set_vec,
    output logic      dis_pulse
);
    localparam int SAT = B2B_LIMIT + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] cnt_q, cnt_d;
    logic          after_setup_tok_q;
    logic          setup_pend_q;
    logic          wr_data_q;
    logic          stat_pend_q;
    logic          dis_q;

    logic tok_any, setup_pkt, setup_done, stat_req, stat_set;

    always_comb begin
        tok_any    = any_data_token(ev);
        setup_pkt  = ev.data_ok && after_setup_tok_q;
        setup_done = tok_any && setup_pend_q;
        stat_req   = (ev.tok_in && wr_data_q) || stat_pend_q;
        stat_set   = stat_req && data_drained;

        cnt_d = cnt_q;
        if (tok_any)
            cnt_d = '0;
        else if (setup_pkt && cnt_q != CW'(SAT))
            cnt_d = cnt_q + 1'b1;

        set_vec               = '0;
        set_vec[F_SETUP_DONE] = setup_done;
        set_vec[F_B2B_SETUP]  = setup_pkt && (cnt_q >= CW'(B2B_LIMIT));
        set_vec[F_OUT_DIS]    = ev.tok_out && !ep_en;
        set_vec[F_STATUS_RX]  = stat_set;
        set_vec[F_PKT_ERR]    = thresh_en && (ev.crc_err || ev.ovf_err);
        set_vec[F_BABBLE]     = ev.babble;
        set_vec[F_NAK]        = ev.nak;
        set_vec[F_NYET]       = ev.nyet;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q             <= '0;
            after_setup_tok_q <= 1'b0;
            setup_pend_q      <= 1'b0;
            wr_data_q         <= 1'b0;
            stat_pend_q       <= 1'b0;
            dis_q             <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            dis_q <= setup_done;

            if (ev.tok_setup)
                after_setup_tok_q <= 1'b1;
            else if (tok_any || ev.data_ok)
                after_setup_tok_q <= 1'b0;

            if (setup_pkt)
                setup_pend_q <= 1'b1;
            else if (tok_any)
                setup_pend_q <= 1'b0;

            if (ev.tok_setup || (ev.tok_in && wr_data_q))
                wr_data_q <= 1'b0;
            else if (ev.tok_out && ep_en && !setup_pend_q)
                wr_data_q <= 1'b1;

            if (ev.tok_setup)
                stat_pend_q <= 1'b0;
            else
                stat_pend_q <= stat_req && !data_drained;
        end
    end

    assign dis_pulse = dis_q;

    AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(SAT)); // R4

    AST_TOKEN_ENDS_PEND: assert property (@(posedge clk) disable iff (rst)
        (tok_any && !setup_pkt) |=> !setup_pend_q); // R2

    AST_TOKEN_RESETS_CNT: assert property (@(posedge clk) disable iff (rst)
        tok_any |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/ctl_ep_flag_bank.sv
module ctl_ep_flag_bank
    import ctl_ep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  flag_vec_t set_i,
    input  flag_vec_t clr_i,
    output flag_vec_t flg_o
);
    flag_vec_t flg_q;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flg_q[i] <= 1'b0;
            else
                flg_q[i] <= set_i[i] | (flg_q[i] & ~clr_i[i]);
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flg_q[i]); // R9

        AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
            (clr_i[i] && !set_i[i]) |=> !flg_q[i]); // R9
    end

    assign flg_o = flg_q;

endmodule

// File: rtl/ctl_ep_irq_merge.sv
module ctl_ep_irq_merge
    import ctl_ep_pkg::*;
(
    input  flag_vec_t flg_i,
    input  flag_vec_t mask_i,
    output logic      irq_o
);
    assign irq_o = |(flg_i & mask_i);
endmodule

// File: rtl/ctl_ep_event_tracker.sv
module ctl_ep_event_tracker
    import ctl_ep_pkg::*;
#(
    parameter int B2B_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_setup,
    input  logic              tok_out,
    input  logic              tok_in,
    input  logic              data_ok,
    input  logic              crc_err,
    input  logic              ovf_err,
    input  logic              babble,
    input  logic              nak_evt,
    input  logic              nyet_evt,
    input  logic              ep_en,
    input  logic              data_drained,
    input  logic              thresh_en,
    input  logic [FLAG_W-1:0] flag_clr,
    input  logic [FLAG_W-1:0] irq_mask,
    output logic [FLAG_W-1:0] flags,
    output logic              irq,
    output logic              ep_dis_pulse
);
    ep_evt_t   ev;
    flag_vec_t set_vec;

    always_comb begin
        ev.tok_setup = tok_setup;
        ev.tok_out   = tok_out;
        ev.tok_in    = tok_in;
        ev.data_ok   = data_ok;
        ev.crc_err   = crc_err;
        ev.ovf_err   = ovf_err;
        ev.babble    = babble;
        ev.nak       = nak_evt;
        ev.nyet      = nyet_evt;
    end

    ctl_ep_phase_fsm #(.B2B_LIMIT(B2B_LIMIT)) u_phase (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .ep_en        (ep_en),
        .data_drained (data_drained),
        .thresh_en    (thresh_en),
        .set_vec      (set_vec),
        .dis_pulse    (ep_dis_pulse)
    );

    ctl_ep_flag_bank u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_vec),
        .clr_i (flag_clr),
        .flg_o (flags)
    );

    ctl_ep_irq_merge u_irq (
        .flg_i  (flags),
        .mask_i (irq_mask),
        .irq_o  (irq)
    );

    AST_DIS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ep_dis_pulse |-> flags[F_SETUP_DONE]); // R3

    AST_STATUS_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_STATUS_RX]) |-> $past(data_drained)); // R6

    AST_PKTERR_GATED: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[F_PKT_ERR]) |-> $past(thresh_en)); // R7

    AST_DIS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ep_dis_pulse |=> !ep_dis_pulse); // R3

endmodule

// File: tb/test_ctl_ep_event_tracker.sv
module test_ctl_ep_event_tracker;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tok_setup = 0, tok_out = 0, tok_in = 0, data_ok = 0;
    logic crc_err = 0, ovf_err = 0, babble = 0, nak_evt = 0, nyet_evt = 0;
    logic ep_en = 1, data_drained = 1, thresh_en = 0;
    logic [7:0] flag_clr = '0;
    logic [7:0] irq_mask = '0;
    logic [7:0] flags;
    logic       irq;
    logic       ep_dis_pulse;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ctl_ep_event_tracker i_ctl_ep_event_tracker (
        .clk(clk), .rst(rst),
        .tok_setup(tok_setup), .tok_out(tok_out), .tok_in(tok_in),
        .data_ok(data_ok), .crc_err(crc_err), .ovf_err(ovf_err),
        .babble(babble), .nak_evt(nak_evt), .nyet_evt(nyet_evt),
        .ep_en(ep_en), .data_drained(data_drained), .thresh_en(thresh_en),
        .flag_clr(flag_clr), .irq_mask(irq_mask),
        .flags(flags), .irq(irq), .ep_dis_pulse(ep_dis_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic send_setup();
        tok_setup = 1'b1;
        @(negedge clk);
        tok_setup = 1'b0;
        data_ok   = 1'b1;
        @(negedge clk);
        data_ok   = 1'b0;
    endtask

    task automatic send_tok(input bit is_in);
        if (is_in) tok_in = 1'b1; else tok_out = 1'b1;
        @(negedge clk);
        tok_in  = 1'b0;
        tok_out = 1'b0;
    endtask

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1 flags", flags, 8'h00);
        check("R1 irq", irq, 1'b0);
        check("R1 ep_dis", ep_dis_pulse, 1'b0);
        send_tok(1'b1);
        check("R1 no setup done without setup", flags[0], 1'b0);

        // R2/R3/R4: sweep setup run length and terminating token kind
        for (int n = 0; n <= 6; n++) begin
            for (int k = 0; k < 2; k++) begin
                do_reset();
                ep_en = 1'b1;
                for (int s = 0; s < n; s++) send_setup();
                check("R2 not before token", flags[0], 1'b0);
                check("R4 b2b after run", flags[1], (n >= 4) ? 1'b1 : 1'b0);
                send_tok(k == 1);
                check("R2 setup done", flags[0], (n >= 1) ? 1'b1 : 1'b0);
                check("R3 dis pulse", ep_dis_pulse, (n >= 1) ? 1'b1 : 1'b0);
                idle();
                check("R3 pulse ends", ep_dis_pulse, 1'b0);
            end
        end

        // R4: token resets the count; three fresh packets do not flag
        do_reset();
        send_setup(); send_setup();
        send_tok(1'b1);
        send_setup(); send_setup(); send_setup();
        check("R4 count reset by token", flags[1], 1'b0);
        send_setup();
        check("R4 fourth after reset", flags[1], 1'b1);

        // R5: OUT while disabled
        do_reset();
        ep_en = 1'b1;
        send_tok(1'b0);
        check("R5 enabled OUT", flags[2], 1'b0);
        ep_en = 1'b0;
        send_tok(1'b1);
        check("R5 IN while disabled", flags[2], 1'b0);
        send_tok(1'b0);
        check("R5 OUT while disabled", flags[2], 1'b1);
        ep_en = 1'b1;

        // R6: status phase waits for drain
        do_reset();
        data_drained = 1'b0;
        send_setup();
        send_tok(1'b0);
        send_tok(1'b0);
        send_tok(1'b1);
        check("R6 held without drain", flags[3], 1'b0);
        idle(); idle(); idle();
        check("R6 still held", flags[3], 1'b0);
        data_drained = 1'b1;
        idle();
        check("R6 set on drain", flags[3], 1'b1);

        do_reset();
        send_setup();
        send_tok(1'b0);
        send_tok(1'b0);
        send_tok(1'b1);
        check("R6 immediate with drain", flags[3], 1'b1);

        do_reset();
        send_setup();
        send_tok(1'b1);
        send_tok(1'b1);
        idle();
        check("R6 control read no status", flags[3], 1'b0);

        // R7: packet error gating sweep
        for (int v = 0; v < 8; v++) begin
            do_reset();
            thresh_en = v[2];
            crc_err   = v[1];
            ovf_err   = v[0];
            idle();
            crc_err = 1'b0;
            ovf_err = 1'b0;
            check("R7 pkt err", flags[4], (v[2] && (v[1] || v[0])) ? 1'b1 : 1'b0);
        end
        thresh_en = 1'b0;

        // R8: line and handshake events
        do_reset();
        babble = 1'b1; idle(); babble = 1'b0;
        check("R8 babble", flags, 8'h20);
        nak_evt = 1'b1; idle(); nak_evt = 1'b0;
        check("R8 nak", flags, 8'h60);
        nyet_evt = 1'b1; idle(); nyet_evt = 1'b0;
        check("R8 nyet", flags, 8'hE0);

        // R9: write-1-to-clear, set wins
        flag_clr = 8'h40; idle(); flag_clr = '0;
        check("R9 clear nak only", flags, 8'hA0);
        nak_evt = 1'b1; flag_clr = 8'h40; idle();
        nak_evt = 1'b0; flag_clr = '0;
        check("R9 set wins", flags[6], 1'b1);
        flag_clr = 8'hFF; idle(); flag_clr = '0;
        check("R9 clear all", flags, 8'h00);

        // R10: mask sweep with bits 5 and 6 set
        babble = 1'b1; nak_evt = 1'b1; idle(); babble = 1'b0; nak_evt = 1'b0;
        for (int m = 0; m < 256; m++) begin
            irq_mask = m[7:0];
            #1;
            check("R10 irq", irq, ((m & 8'h60) != 0) ? 1'b1 : 1'b0);
        end
        irq_mask = '0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule